// File: doc/BRIEF.md
# Host Configuration Access Bridge

This block sits on the host side of a parallel PCI-style bus and gives the processor a way to reach the configuration space of targets on that bus. The processor sees two fixed I/O locations: an address location and a data window. A write to the address location only records which bus, device, function and dword register the next access should reach. An access to the data window is what starts a configuration cycle on the bus. A read returns the target's data through the same window. A write carries the host's value to the target.

On the local bus (bus number 0), the device number is turned into a single select line among the upper address/data lines. Each slot's IDSEL input is wired to its own line. On any other bus number, the address phase carries the bus, device, function and register fields unchanged and marks the low address bits as 01, so that a downstream bridge can pick the cycle up.

A target that never claims the cycle does not hang the host. After a fixed number of clocks the cycle ends as a master abort, and a read then returns all ones. While a configuration cycle is in flight, the host side holds a not-ready signal high, so only one cycle is outstanding at a time.

Top module: `cfg_host_bridge`

## Requirements
- R1: The address location stores an enable in bit 31, the bus number in bits 23:16, the device in bits 15:11, the function in bits 10:8 and the dword register index in bits 7:2. Reading it back returns these fields, with bits 30:24 and 1:0 reading as zero. The address location is selected by `host_sel_data`=0 and the data window by `host_sel_data`=1.
- R2: A host access to the address location completes on the next clock, with `host_done` high. It starts no bus cycle.
- R3: With the enable bit set, a data-window access drives a one-clock address phase (`bus_frame` high) followed by a data phase (`bus_irdy` high). The command is 4'hA for a read and 4'hB for a write.
- R4: For bus number 0, the address phase carries a select line in AD[31:11], the function in AD[10:8], the register index in AD[7:2] and 2'b00 in AD[1:0]. Device d drives AD[11+d].
- R5: For bus number 0, at most one of AD[31:11] is high in the address phase, and device numbers 21 to 31 drive none of them.
- R6: For a nonzero bus number, the address phase carries the bus in AD[23:16], the device in AD[15:11], the function in AD[10:8], the register index in AD[7:2] and 2'b01 in AD[1:0], with AD[31:24] zero.
- R7: A data-window read returns the value that the target places on `bus_ad_in` in the data-phase clock where `bus_trdy` and `bus_devsel` are both high. `host_done` rises one clock later, which is 3+k clocks after the request when the target answers in the k-th data-phase clock (counting from 0).
- R8: A data-window write drives the host's value on `bus_ad_out` with `bus_ad_oe` high throughout the data phase.
- R9: With the enable bit clear, data-window accesses start no bus cycle and complete on the next clock. Reads return 32'hFFFFFFFF and writes are discarded.
- R10: If `bus_devsel` stays low for ABORT_CLKS data-phase clocks, the cycle ends as a master abort. `host_done` follows 2+ABORT_CLKS clocks after the request, and a read returns 32'hFFFFFFFF. A claim in the last of those clocks still completes normally.
- R11: `host_wait` is high from the clock after a data-window request until the cycle ends, and low whenever `host_done` is high. Requests made while `host_wait` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Host access request, one clock |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_sel_data | input | 1 | 0 = address location, 1 = data window |
| host_wdata | input | 32 | Host write value |
| host_rdata | output | 32 | Read result, valid with host_done |
| host_done | output | 1 | Access complete, one clock |
| host_wait | output | 1 | Configuration cycle in progress |
| bus_frame | output | 1 | Address phase marker |
| bus_irdy | output | 1 | Data phase, initiator ready |
| bus_cmd | output | 4 | Bus command during the address phase |
| bus_ad_oe | output | 1 | Address/data output enable |
| bus_ad_out | output | 32 | Address/data lines driven by the bridge |
| bus_ad_in | input | 32 | Address/data lines driven by the target |
| bus_devsel | input | 1 | Target claims the cycle |
| bus_trdy | input | 1 | Target ready |

## Verification
If the stored address fields are corrupted, the next address phase shows a wrong or doubled select line, or wrong field bits. This is visible on the first configuration cycle after the corruption. If the sequencer state is wrong, `host_done` moves away from its exact latency (3+k clocks for a claim in data clock k, 2+ABORT_CLKS clocks for an abort), or `bus_frame` appears on accesses that must not start a cycle. The latency is compared to the exact clock on every access. A mis-captured read value or write value appears in `host_rdata` or in the target's stored dword at the end of that same access.

// File: rtl/cfg_host_bridge.sv
module cfg_host_bridge #(
  parameter int ABORT_CLKS = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        host_req,
  input  logic        host_wr,
  input  logic        host_sel_data,
  input  logic [31:0] host_wdata,
  output logic [31:0] host_rdata,
  output logic        host_done,
  output logic        host_wait,
  output logic        bus_frame,
  output logic        bus_irdy,
  output logic [3:0]  bus_cmd,
  output logic        bus_ad_oe,
  output logic [31:0] bus_ad_out,
  input  logic [31:0] bus_ad_in,
  input  logic        bus_devsel,
  input  logic        bus_trdy
);
  localparam int CNT_W    = (ABORT_CLKS > 1) ? $clog2(ABORT_CLKS) : 1;
  localparam int SEL_LO   = 11;
  localparam int SEL_N    = 32 - SEL_LO;
  localparam logic [3:0] CMD_RD = 4'hA;
  localparam logic [3:0] CMD_WR = 4'hB;

  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA} seq_t;
  seq_t state;

  logic             en_q;
  logic [7:0]       bus_q;
  logic [4:0]       dev_q;
  logic [2:0]       fn_q;
  logic [5:0]       reg_q;
  logic             is_wr;
  logic             claimed;
  logic [CNT_W-1:0] cnt;
  logic [31:0]      wdata_q;
  logic [SEL_N-1:0] idsel;
  logic [31:0]      ad_addr;
  logic             unused_bits;

  assign unused_bits = ^{host_wdata[30:24], host_wdata[1:0]};

  assign idsel   = (dev_q < 5'(SEL_N)) ? (SEL_N'(1) << dev_q) : '0;
  assign ad_addr = (bus_q == 8'd0) ? {idsel, fn_q, reg_q, 2'b00}
                                   : {8'h00, bus_q, dev_q, fn_q, reg_q, 2'b01};

  assign host_wait  = (state != ST_IDLE);
  assign bus_frame  = (state == ST_ADDR);
  assign bus_irdy   = (state == ST_DATA);
  assign bus_cmd    = bus_frame ? (is_wr ? CMD_WR : CMD_RD) : 4'h0;
  assign bus_ad_oe  = bus_frame || (bus_irdy && is_wr);
  assign bus_ad_out = bus_frame ? ad_addr : ((bus_irdy && is_wr) ? wdata_q : 32'h0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      en_q       <= 1'b0;
      bus_q      <= '0;
      dev_q      <= '0;
      fn_q       <= '0;
      reg_q      <= '0;
      is_wr      <= 1'b0;
      claimed    <= 1'b0;
      cnt        <= '0;
      wdata_q    <= '0;
      host_rdata <= '0;
      host_done  <= 1'b0;
    end else begin
      host_done <= 1'b0;
      case (state)
        ST_IDLE: if (host_req) begin
          if (!host_sel_data) begin
            if (host_wr) begin
              en_q  <= host_wdata[31];
              bus_q <= host_wdata[23:16];
              dev_q <= host_wdata[15:11];
              fn_q  <= host_wdata[10:8];
              reg_q <= host_wdata[7:2];
            end else begin
              host_rdata <= {en_q, 7'b0, bus_q, dev_q, fn_q, reg_q, 2'b00};
            end
            host_done <= 1'b1;
          end else if (!en_q) begin
            if (!host_wr) host_rdata <= 32'hFFFF_FFFF;
            host_done <= 1'b1;
          end else begin
            is_wr   <= host_wr;
            wdata_q <= host_wdata;
            state   <= ST_ADDR;
          end
        end
        ST_ADDR: begin
          cnt     <= '0;
          claimed <= 1'b0;
          state   <= ST_DATA;
        end
        ST_DATA: begin
          if (bus_trdy && (bus_devsel || claimed)) begin
            if (!is_wr) host_rdata <= bus_ad_in;
            host_done <= 1'b1;
            state     <= ST_IDLE;
          end else if (!claimed && !bus_devsel) begin
            if (cnt == CNT_W'(ABORT_CLKS - 1)) begin
              if (!is_wr) host_rdata <= 32'hFFFF_FFFF;
              host_done <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              cnt <= cnt + 1'b1;
            end
          end else begin
            claimed <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2: address-location accesses never open a bus cycle
  p_addr_no_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && !host_sel_data && !host_wait) |=> (!bus_frame && host_done));

  // R3: one-clock address phase followed by a data phase
  p_frame_then_irdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_frame |=> (!bus_frame && bus_irdy));

  // R5: at most one select line on a local-bus address phase
  p_select_onehot_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_frame && bus_ad_out[1:0] == 2'b00) |-> $onehot0(bus_ad_out[31:11]));

  // R9: disabled data-window read returns all ones without a cycle
  p_disabled_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (host_req && host_sel_data && !host_wr && !host_wait && !en_q) |=>
      (host_done && host_rdata == 32'hFFFF_FFFF && !bus_frame));

  // R11: completion never overlaps the not-ready indication
  p_done_not_waiting_r11: assert property (@(posedge clk) disable iff (!rst_n)
    host_done |-> !host_wait);
endmodule

// File: tb/test_cfg_host_bridge.sv
`timescale 1ns/1ps
module test_cfg_host_bridge;
  localparam int ABORT = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req = 1'b0, host_wr = 1'b0, host_sel_data = 1'b0;
  logic [31:0] host_wdata = '0;
  logic [31:0] host_rdata;
  logic        host_done, host_wait;
  logic        bus_frame, bus_irdy, bus_ad_oe;
  logic [3:0]  bus_cmd;
  logic [31:0] bus_ad_out;
  logic [31:0] bus_ad_in = '0;
  logic        bus_devsel = 1'b0, bus_trdy = 1'b0;

  always #2 clk = ~clk;

  cfg_host_bridge #(.ABORT_CLKS(ABORT)) i_cfg_host_bridge (
    .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_wr(host_wr),
    .host_sel_data(host_sel_data), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .host_done(host_done), .host_wait(host_wait),
    .bus_frame(bus_frame), .bus_irdy(bus_irdy), .bus_cmd(bus_cmd),
    .bus_ad_oe(bus_ad_oe), .bus_ad_out(bus_ad_out), .bus_ad_in(bus_ad_in),
    .bus_devsel(bus_devsel), .bus_trdy(bus_trdy));

  int errors = 0, checks = 0, frames = 0;
  bit reported = 0;

  // target model
  int          tgt_dev = 3;
  int          tgt_delay = 0;
  bit          tgt_on = 1;
  logic [31:0] mem [0:63];
  logic [31:0] cap_ad;
  logic [3:0]  cap_cmd;
  bit          hit = 0;
  int          k = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  always @(posedge clk) if (bus_frame) frames++;

  always @(negedge clk) begin
    if (bus_frame) begin
      cap_ad  = bus_ad_out;
      cap_cmd = bus_cmd;
      hit = tgt_on && ((bus_ad_out[1:0] == 2'b01) ||
            (tgt_dev < 21 && bus_ad_out[11 + tgt_dev]));
      k = 0;
      checks++;
      if (!host_wait) begin errors++; $display("FAIL R11 actual=0 expected=1 (wait in address phase)"); end
    end
    if (bus_irdy) begin
      if (hit && k == tgt_delay) begin
        bus_devsel = 1; bus_trdy = 1;
        bus_ad_in = mem[cap_ad[7:2]];
        if (cap_cmd == 4'hB) begin
          checks++;
          if (!bus_ad_oe) begin errors++; $display("FAIL R8 actual=0 expected=1 (oe in write data)"); end
          mem[cap_ad[7:2]] = bus_ad_out;
        end
      end else begin
        bus_devsel = 0; bus_trdy = 0;
      end
      k++;
    end else begin
      bus_devsel = 0; bus_trdy = 0; bus_ad_in = '0;
    end
  end

  task automatic access(input bit wr, input bit sel, input logic [31:0] wd,
                        input int exp_n, input bit chk_rd, input logic [31:0] exp_rd,
                        input string req);
    int n;
    @(negedge clk);
    host_req = 1; host_wr = wr; host_sel_data = sel; host_wdata = wd;
    @(negedge clk);
    host_req = 0;
    n = 1;
    while (!host_done && n < 100) begin
      if (!host_wait) begin
        checks++; errors++;
        $display("FAIL R11 actual=0 expected=1 (host_wait at clock %0d)", n);
      end
      @(negedge clk);
      n++;
    end
    chk(n == exp_n, {req, " latency"}, n, exp_n);
    if (chk_rd) chk(host_rdata == exp_rd, {req, " read data"}, host_rdata, exp_rd);
  endtask

  function automatic logic [31:0] caddr(bit en, int b, int d, int f, int r);
    return {en, 7'b0, 8'(b), 5'(d), 3'(f), 6'(r), 2'b00};
  endfunction

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    report();
  end

  initial begin
    int f0;
    for (int i = 0; i < 64; i++) mem[i] = 32'h1000_0000 + i;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // reset state (R11, R3)
    chk(!host_wait && !bus_frame && !bus_irdy && !bus_ad_oe, "R11 reset",
        {host_wait, bus_frame, bus_irdy, bus_ad_oe}, 0);

    // R1, R2: address location write and read back
    f0 = frames;
    access(1, 0, 32'hFFFF_FFFF, 1, 0, 0, "R2 addr write");
    access(0, 0, 0, 1, 1, 32'h80FF_FFFC, "R1 addr readback");
    chk(frames == f0, "R2 no bus cycle", frames - f0, 0);

    // R4, R8: local write to dev 3 fn 2 reg 5
    tgt_dev = 3; tgt_delay = 0;
    access(1, 0, caddr(1, 0, 3, 2, 5), 1, 0, 0, "R2 addr set");
    access(1, 1, 32'hA5A5_0001, 3, 0, 0, "R8 write");
    chk(cap_ad == ((32'h1 << 14) | (2 << 8) | (5 << 2)), "R4 address phase", cap_ad,
        (32'h1 << 14) | (2 << 8) | (5 << 2));
    chk(cap_cmd == 4'hB, "R3 write command", cap_cmd, 4'hB);
    chk(mem[5] == 32'hA5A5_0001, "R8 target data", mem[5], 32'hA5A5_0001);

    // R7: read with delay 2
    tgt_delay = 2;
    access(0, 1, 0, 5, 1, 32'hA5A5_0001, "R7 read delay2");
    chk(cap_cmd == 4'hA, "R3 read command", cap_cmd, 4'hA);

    // R10 boundary: claim in last clock
    tgt_delay = ABORT - 1;
    access(0, 1, 0, 3 + ABORT - 1, 1, 32'hA5A5_0001, "R10 late claim");

    // R10: no target at dev 4
    tgt_delay = 0;
    access(1, 0, caddr(1, 0, 4, 0, 1), 1, 0, 0, "R2 addr set");
    access(0, 1, 0, 2 + ABORT, 1, 32'hFFFF_FFFF, "R10 master abort read");
    access(1, 1, 32'h5555_5555, 2 + ABORT, 0, 0, "R10 master abort write");
    chk(mem[1] == 32'h1000_0001, "R10 abort write lost", mem[1], 32'h1000_0001);

    // R5: device 21 selects no line
    access(1, 0, caddr(1, 0, 21, 0, 0), 1, 0, 0, "R2 addr set");
    access(0, 1, 0, 2 + ABORT, 1, 32'hFFFF_FFFF, "R5 dev21 abort");
    chk(cap_ad[31:11] == 0, "R5 no select line", cap_ad, 0);

    // R4/R5: device 20 drives AD31
    tgt_dev = 20;
    access(1, 0, caddr(1, 0, 20, 7, 63), 1, 0, 0, "R2 addr set");
    access(0, 1, 0, 3, 1, 32'h1000_003F, "R4 dev20 read");
    chk(cap_ad == 32'h8000_07FC, "R4 dev20 address", cap_ad, 32'h8000_07FC);

    // R6: other bus number
    access(1, 0, caddr(1, 5, 9, 1, 2), 1, 0, 0, "R2 addr set");
    access(0, 1, 0, 3, 1, 32'h1000_0002, "R6 remote read");
    chk(cap_ad == 32'h0005_4909, "R6 address phase", cap_ad, 32'h0005_4909);

    // R9: disabled
    tgt_dev = 3;
    f0 = frames;
    access(1, 0, caddr(0, 0, 3, 2, 5), 1, 0, 0, "R2 addr set");
    access(1, 1, 32'hDEAD_BEEF, 1, 0, 0, "R9 disabled write");
    access(0, 1, 0, 1, 1, 32'hFFFF_FFFF, "R9 disabled read");
    chk(frames == f0, "R9 no bus cycle", frames - f0, 0);
    access(1, 0, caddr(1, 0, 3, 2, 5), 1, 0, 0, "R2 addr set");
    access(0, 1, 0, 3, 1, 32'hA5A5_0001, "R9 write discarded");

    // R11: request during busy ignored
    f0 = frames;
    tgt_delay = 3;
    @(negedge clk);
    host_req = 1; host_wr = 0; host_sel_data = 1;
    @(negedge clk);
    host_req = 1;
    @(negedge clk);
    host_req = 0;
    repeat (12) @(negedge clk);
    chk(frames == f0 + 1, "R11 busy request ignored", frames - f0, 1);

    report();
  end
endmodule